// File: doc/BRIEF.md
# Spectral Energy Detector

This block decides whether a transmitter is present in a digitised band and, if one is, where its carrier sits. It receives a stream of complex frequency-domain bins, one observation window after another, each window holding a fixed number of bins in ascending bin order. It squares each bin's magnitude and sums the results bin by bin over a power-of-two number of windows, which gives an averaged power spectrum.

When the last bin of the final window arrives, the block stops accepting data and scans the averaged spectrum. Each bin is smoothed with a moving average over its neighbours and compared against a threshold supplied on an input. The carrier estimate is the midpoint between the lowest and the highest bin found above the threshold. A one-cycle pulse then reports the decision and the carrier bin. Both values stay on the outputs until the next result.

The input is a valid/ready stream. A bin is taken on every rising edge where `in_valid` and `in_ready` are both high. The source must keep `in_re`/`in_im` stable while `in_valid` is high and `in_ready` is low. The block lowers `in_ready` only during the scan, and may do so while `in_valid` is high. `in_valid` may drop at any time between bins.

Top module: `spec_energy_det`

## Requirements
- R1: The power of a bin is re*re + im*im of the two's-complement inputs, kept at full precision. Per bin, the powers of 2^LOG2_WIN consecutive windows are added and the sum is shifted right by LOG2_WIN, discarding the fraction.
- R2: A bin is consumed only on an edge with in_valid and in_ready both high. Consumed bins are numbered 0 to NBINS-1 within a window and windows follow one another without any separator. Idle cycles between bins have no effect on the result.
- R3: in_ready is low from the edge that consumes bin NBINS-1 of the final window until the result is issued. Nothing offered during that time is consumed, and in_ready is high again in the cycle in which res_valid is high.
- R4: The smoothed value of bin j averages the averaged bins j-HALF_SPAN..j+HALF_SPAN that exist. Near the ends only the bins in range are used, so the count drops to HALF_SPAN+1 at bins 0 and NBINS-1. Bin j is above threshold when its window sum is strictly greater than threshold times the number of bins in the window.
- R5: det_flag is 1 in a result exactly when at least one bin is above threshold.
- R6: When det_flag is 1, carrier_bin equals floor((first + last) / 2), where first and last are the lowest and highest bins above threshold.
- R7: When no bin is above threshold, det_flag is 0 and carrier_bin is 0.
- R8: res_valid is high for exactly one cycle. It rises on the NBINS-th rising edge after the edge that consumed the final bin.
- R9: After reset, in_ready is 1, res_valid is 0, det_flag is 0 and carrier_bin is 0. det_flag and carrier_bin change only on the edge that raises res_valid.
- R10: Each new batch starts its averages from zero, so earlier batches have no influence on a later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bin is offered on in_re/in_im |
| in_ready | output | 1 | The block can consume a bin |
| in_re | input | IQ_W | Real part of the bin, two's complement |
| in_im | input | IQ_W | Imaginary part of the bin, two's complement |
| threshold | input | 2*IQ_W | Decision threshold for a smoothed bin, unsigned |
| res_valid | output | 1 | One-cycle pulse: a new result is on the outputs |
| det_flag | output | 1 | A signal was found in the last result |
| carrier_bin | output | clog2(NBINS) | Estimated carrier bin of the last result |

## Verification
The hardest conditions to reach from the ports are those that depend on values inside the averaging and the smoothing. One is the edge window, where fewer neighbours count. Another is the truncation of the window average, which can change a decision right at the threshold. The stimulus reaches these with spectra built for the purpose. One puts a lone strong bin at either end of the band, with a threshold between a third and a quarter of its power. Another places a uniform spectrum whose exact mean lies just above the threshold but whose truncated mean does not. Back-pressure is exercised by holding in_valid high with loud junk data throughout the scan. A following batch must then produce the same result as an undisturbed run.

// File: rtl/sed_pkg.sv
package sed_pkg;

  // Operating phase of the detector: gathering bins or scanning the spectrum.
  typedef enum logic [0:0] {
    PH_GATHER = 1'b0,
    PH_SCAN   = 1'b1
  } phase_e;

endpackage

// File: rtl/sed_power.sv
// Full-precision bin power: re^2 + im^2 of two's-complement inputs.
module sed_power #(
  parameter int IQ_W = 12,
  localparam int PW  = 2 * IQ_W
) (
  input  logic signed [IQ_W-1:0] re_i,
  input  logic signed [IQ_W-1:0] im_i,
  output logic        [PW-1:0]   pwr_o
);

  logic signed [PW-1:0] re_x;
  logic signed [PW-1:0] im_x;
  logic signed [PW-1:0] re_sq;
  logic signed [PW-1:0] im_sq;

  always_comb begin
    re_x  = PW'(re_i);
    im_x  = PW'(im_i);
    re_sq = re_x * re_x;
    im_sq = im_x * im_x;
    pwr_o = unsigned'(re_sq) + unsigned'(im_sq);
  end

endmodule

// File: rtl/sed_bin_store.sv
// Per-bin power accumulator across windows; exposes the shifted mean of every bin.
module sed_bin_store #(
  parameter int NBINS    = 64,
  parameter int PW       = 24,
  parameter int LOG2_WIN = 2,
  localparam int IDXW    = $clog2(NBINS),
  localparam int ACW     = PW + LOG2_WIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic            wr_first_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [PW-1:0]   wr_pwr_i,
  output logic [PW-1:0]   avg_o [NBINS]
);

  logic [ACW-1:0] acc_q [NBINS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBINS; i++) acc_q[i] <= '0;
    end else if (wr_en_i) begin
      if (wr_first_i) acc_q[wr_idx_i] <= ACW'(wr_pwr_i);
      else            acc_q[wr_idx_i] <= acc_q[wr_idx_i] + ACW'(wr_pwr_i);
    end
  end

  // Mean over 2^LOG2_WIN windows is the upper PW bits of the sum.
  for (genvar g = 0; g < NBINS; g++) begin : g_mean
    assign avg_o[g] = acc_q[g][ACW-1:LOG2_WIN];
  end

endmodule

// File: rtl/sed_smoother.sv
// Edge-aware moving window around one centre bin, and the threshold test on it.
module sed_smoother #(
  parameter int NBINS     = 64,
  parameter int PW        = 24,
  parameter int HALF_SPAN = 2,
  localparam int IDXW     = $clog2(NBINS),
  localparam int TAPS     = 2 * HALF_SPAN + 1,
  localparam int CW       = $clog2(TAPS + 1),
  localparam int SW       = PW + CW
) (
  input  logic [PW-1:0]   avg_i [NBINS],
  input  logic [IDXW-1:0] centre_i,
  input  logic [PW-1:0]   thr_i,
  output logic            above_o
);

  logic [SW-1:0] sum_c;
  logic [CW-1:0] cnt_c;
  logic [SW-1:0] limit_c;

  always_comb begin
    sum_c = '0;
    cnt_c = '0;
    for (int t = 0; t < TAPS; t++) begin
      int pos;
      pos = int'(centre_i) + t - HALF_SPAN;
      if (pos >= 0 && pos < NBINS) begin
        sum_c = sum_c + SW'(avg_i[pos[IDXW-1:0]]);
        cnt_c = cnt_c + CW'(1);
      end
    end
    // Compare sum against thr*count instead of dividing the sum.
    limit_c = SW'(thr_i) * SW'(cnt_c);
    above_o = (sum_c > limit_c);
  end

endmodule

// File: rtl/sed_locator.sv
// Tracks first/last bins above threshold during the scan and issues the result.
module sed_locator #(
  parameter int NBINS = 64,
  localparam int IDXW = $clog2(NBINS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_act_i,
  input  logic [IDXW-1:0] scan_idx_i,
  input  logic            scan_last_i,
  input  logic            above_i,
  output logic            res_valid_o,
  output logic            det_o,
  output logic [IDXW-1:0] bin_o
);

  logic            seen_q;
  logic [IDXW-1:0] first_q;
  logic [IDXW-1:0] last_q;

  logic            seen_base;
  logic            seen_n;
  logic [IDXW-1:0] first_n;
  logic [IDXW-1:0] last_n;
  logic [IDXW:0]   mid_sum;

  always_comb begin
    // The scan starts at bin 0, so tracking restarts there.
    seen_base = (scan_idx_i == '0) ? 1'b0 : seen_q;
    seen_n    = seen_base | above_i;
    first_n   = (above_i && !seen_base) ? scan_idx_i : first_q;
    last_n    = above_i ? scan_idx_i : last_q;
    mid_sum   = {1'b0, first_n} + {1'b0, last_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      first_q     <= '0;
      last_q      <= '0;
      res_valid_o <= 1'b0;
      det_o       <= 1'b0;
      bin_o       <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (scan_act_i) begin
        seen_q  <= seen_n;
        first_q <= first_n;
        last_q  <= last_n;
        if (scan_last_i) begin
          res_valid_o <= 1'b1;
          det_o       <= seen_n;
          bin_o       <= seen_n ? mid_sum[IDXW:1] : '0;
        end
      end
    end
  end

endmodule

// File: rtl/spec_energy_det.sv
// Spectral energy detector: averaged PSD, bin smoothing, threshold, carrier midpoint.
module spec_energy_det #(
  parameter int IQ_W      = 12,
  parameter int NBINS     = 64,
  parameter int LOG2_WIN  = 2,
  parameter int HALF_SPAN = 2,
  localparam int PW       = 2 * IQ_W,
  localparam int IDXW     = $clog2(NBINS),
  localparam int WINS     = 1 << LOG2_WIN,
  localparam int WINW     = (LOG2_WIN > 0) ? LOG2_WIN : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IQ_W-1:0] in_re,
  input  logic signed [IQ_W-1:0] in_im,
  input  logic        [PW-1:0]   threshold,
  output logic                   res_valid,
  output logic                   det_flag,
  output logic        [IDXW-1:0] carrier_bin
);

  import sed_pkg::*;

  phase_e          phase_q;
  logic [IDXW-1:0] bin_q;
  logic [WINW-1:0] win_q;
  logic [IDXW-1:0] scan_q;

  logic            take;
  logic            bin_end;
  logic            win_end;
  logic            scan_act;
  logic            scan_end;
  logic [PW-1:0]   bin_pwr;
  logic [PW-1:0]   avg_bins [NBINS];
  logic            bin_above;

  assign in_ready = (phase_q == PH_GATHER);
  assign take     = in_valid && in_ready;
  assign bin_end  = (bin_q == IDXW'(NBINS - 1));
  assign win_end  = (win_q == WINW'(WINS - 1));
  assign scan_act = (phase_q == PH_SCAN);
  assign scan_end = (scan_q == IDXW'(NBINS - 1));

  // Phase, bin and window sequencing.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_GATHER;
      bin_q   <= '0;
      win_q   <= '0;
      scan_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_GATHER: begin
          if (take) begin
            if (bin_end) begin
              bin_q <= '0;
              if (win_end) begin
                win_q   <= '0;
                scan_q  <= '0;
                phase_q <= PH_SCAN;
              end else begin
                win_q <= win_q + WINW'(1);
              end
            end else begin
              bin_q <= bin_q + IDXW'(1);
            end
          end
        end
        PH_SCAN: begin
          if (scan_end) begin
            scan_q  <= '0;
            phase_q <= PH_GATHER;
          end else begin
            scan_q <= scan_q + IDXW'(1);
          end
        end
        default: phase_q <= PH_GATHER;
      endcase
    end
  end

  sed_power #(
    .IQ_W (IQ_W)
  ) u_power (
    .re_i  (in_re),
    .im_i  (in_im),
    .pwr_o (bin_pwr)
  );

  sed_bin_store #(
    .NBINS    (NBINS),
    .PW       (PW),
    .LOG2_WIN (LOG2_WIN)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (take),
    .wr_first_i (win_q == '0),
    .wr_idx_i   (bin_q),
    .wr_pwr_i   (bin_pwr),
    .avg_o      (avg_bins)
  );

  sed_smoother #(
    .NBINS     (NBINS),
    .PW        (PW),
    .HALF_SPAN (HALF_SPAN)
  ) u_smooth (
    .avg_i    (avg_bins),
    .centre_i (scan_q),
    .thr_i    (threshold),
    .above_o  (bin_above)
  );

  sed_locator #(
    .NBINS (NBINS)
  ) u_locate (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_act_i  (scan_act),
    .scan_idx_i  (scan_q),
    .scan_last_i (scan_end),
    .above_i     (bin_above),
    .res_valid_o (res_valid),
    .det_o       (det_flag),
    .bin_o       (carrier_bin)
  );

endmodule

// File: rtl/sed_checker.sv
// Temporal checks on the detector, bound to the top module.
module sed_checker #(
  parameter int NBINS = 64,
  parameter int IDXW  = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            res_valid,
  input logic            det_flag,
  input logic [IDXW-1:0] carrier_bin,
  input logic            scan_act
);

  // Cycles spent with the input blocked; checked against NBINS at the result.
  logic [IDXW+1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (in_ready) busy_cnt <= '0;
    else               busy_cnt <= busy_cnt + 1'b1;
  end

  AST_SCAN_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    scan_act |-> !in_ready);  // R3
  AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready);  // R3
  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);  // R8
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (busy_cnt == (IDXW+2)'(NBINS)));  // R8
  AST_EMPTY_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !det_flag |-> (carrier_bin == '0));  // R7
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_bin <= IDXW'(NBINS - 1));  // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(det_flag) && $stable(carrier_bin)));  // R9

endmodule

bind spec_energy_det sed_checker #(
  .NBINS (NBINS),
  .IDXW  (IDXW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .res_valid   (res_valid),
  .det_flag    (det_flag),
  .carrier_bin (carrier_bin),
  .scan_act    (scan_act)
);

// File: tb/spec_energy_det_tb_top.sv
`timescale 1ns/1ps
module spec_energy_det_tb_top;

  localparam int IQ_W  = 12;
  localparam int NB    = 64;
  localparam int L2W   = 2;
  localparam int NW    = 1 << L2W;
  localparam int PW    = 2 * IQ_W;
  localparam int IDXW  = $clog2(NB);

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic signed [IQ_W-1:0] in_re = '0;
  logic signed [IQ_W-1:0] in_im = '0;
  logic        [PW-1:0]   threshold = '0;
  logic                   res_valid;
  logic                   det_flag;
  logic        [IDXW-1:0] carrier_bin;

  int total = 0;
  int bad   = 0;

  logic signed [IQ_W-1:0] st_re [NW][NB];
  logic signed [IQ_W-1:0] st_im [NW][NB];

  always #4 clk = ~clk;  // 125 MHz

  spec_energy_det #(
    .IQ_W (IQ_W), .NBINS (NB), .LOG2_WIN (L2W), .HALF_SPAN (2)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_re (in_re), .in_im (in_im), .threshold (threshold),
    .res_valid (res_valid), .det_flag (det_flag), .carrier_bin (carrier_bin)
  );

  task automatic check(input longint act, input longint exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic stim_fill(input int re, input int im);
    for (int w = 0; w < NW; w++)
      for (int b = 0; b < NB; b++) begin
        st_re[w][b] = IQ_W'(re);
        st_im[w][b] = IQ_W'(im);
      end
  endtask

  task automatic stim_bin(input int b, input int re, input int im);
    for (int w = 0; w < NW; w++) begin
      st_re[w][b] = IQ_W'(re);
      st_im[w][b] = IQ_W'(im);
    end
  endtask

  // Tone over bins 20..26 on a faint floor: region above 1000 is 18..28, centre 23.
  task automatic stim_tone();
    stim_fill(3, 0);
    for (int b = 20; b <= 26; b++) stim_bin(b, 300, -200);
  endtask

  // Sends one batch, waits for the result and checks decision, latency and blocking.
  task automatic run_batch(input longint thr, input bit gaps, input bit junk,
                           input int exp_det, input int exp_bin, input string req);
    int cyc;
    bit ready_low_ok;
    threshold = PW'(thr);
    for (int w = 0; w < NW; w++)
      for (int b = 0; b < NB; b++) begin
        if (gaps && (b % 5 == 2)) begin
          @(negedge clk); in_valid = 1'b0;
          @(negedge clk);
        end else begin
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_re = st_re[w][b];
        in_im = st_im[w][b];
        #1;
        if (!in_ready) begin
          total++; bad++;
          $display("FAIL R2 ready low while gathering: actual=0 expected=1");
        end
        @(posedge clk);
      end
    cyc = 0;
    ready_low_ok = 1'b1;
    for (int k = 0; k < NB + 8; k++) begin
      @(negedge clk);
      if (res_valid) begin
        in_valid = 1'b0;
        break;
      end
      in_valid = junk;
      in_re    = 12'sd2047;
      in_im    = -12'sd2048;
      if (in_ready) ready_low_ok = 1'b0;
      @(posedge clk);
      cyc++;
    end
    check(longint'(res_valid), 1, "R8", "result pulse seen");
    check(cyc, NB, "R8", "edges from final bin to result");
    check(longint'(ready_low_ok), 1, "R3", "ready low during scan");
    check(longint'(in_ready), 1, "R3", "ready back with result");
    check(longint'(det_flag), exp_det, req, "detect flag");
    check(longint'(carrier_bin), exp_bin, req, "carrier bin");
    @(negedge clk);
    check(longint'(res_valid), 0, "R8", "pulse width one cycle");
  endtask

  task automatic t_reset();
    check(longint'(in_ready), 1, "R9", "reset ready");
    check(longint'(res_valid), 0, "R9", "reset res_valid");
    check(longint'(det_flag), 0, "R9", "reset det_flag");
    check(longint'(carrier_bin), 0, "R9", "reset carrier_bin");
  endtask

  task automatic t_tone();  // R4 R5 R6
    stim_tone();
    run_batch(1000, 1'b0, 1'b0, 1, 23, "R6");
  endtask

  task automatic t_empty_after_tone();  // R7 R10
    stim_fill(0, 0);
    run_batch(0, 1'b0, 1'b0, 0, 0, "R10");
  endtask

  task automatic t_edges();  // R4: lone bin at an end passes only with count 3
    stim_fill(0, 0);
    stim_bin(0, 100, 0);
    run_batch(3000, 1'b0, 1'b0, 1, 0, "R4");
    stim_fill(0, 0);
    stim_bin(NB - 1, 0, -100);
    run_batch(3000, 1'b0, 1'b0, 1, NB - 1, "R4");
    stim_fill(0, 0);
    stim_bin(0, 100, 0);
    stim_bin(NB - 1, 100, 0);
    run_batch(3000, 1'b0, 1'b0, 1, 31, "R6");  // floor(63/2)
  endtask

  task automatic t_truncation();  // R1: powers 1,4,4,4 average to 3, not 3.25
    stim_fill(0, 0);
    for (int b = 0; b < NB; b++) begin
      st_re[0][b] = 12'sd1;
      for (int w = 1; w < NW; w++) st_re[w][b] = 12'sd2;
    end
    run_batch(3, 1'b0, 1'b0, 0, 0, "R1");
    run_batch(2, 1'b0, 1'b0, 1, 31, "R1");
  endtask

  task automatic t_extreme();  // R1: -2048,-2048 gives 2^23 per bin
    stim_fill(-2048, -2048);
    run_batch(8388607, 1'b0, 1'b0, 1, 31, "R1");
    run_batch(8388608, 1'b0, 1'b0, 0, 0, "R5");
  endtask

  task automatic t_stall_and_block();  // R2 R3
    stim_tone();
    run_batch(1000, 1'b1, 1'b1, 1, 23, "R2");
    run_batch(1000, 1'b0, 1'b0, 1, 23, "R3");
  endtask

  task automatic t_hold();  // R9
    logic d0;
    logic [IDXW-1:0] b0;
    d0 = det_flag;
    b0 = carrier_bin;
    repeat (20) @(negedge clk);
    check(longint'(det_flag), longint'(d0), "R9", "flag held");
    check(longint'(carrier_bin), longint'(b0), "R9", "bin held");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tone();
    t_hold();
    t_empty_after_tone();
    t_edges();
    t_truncation();
    t_extreme();
    t_stall_and_block();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule